// File: doc/BRIEF.md
# Peripheral Access Stall Generator

This block tells the CPU how long to hold off when it touches a slow peripheral register window. The stall is charged once per instruction, not once per bus cycle. For each access, the bus side presents three things: a strobe, a stamp that names the instruction making the access, and a flag that marks multi-register burst moves. A separate filter decides whether the access is genuine and reports that on a validity input.

The first genuine access made by an instruction always costs a stall of `STALL_LEN` clocks. Later accesses from the same instruction are free. The exception is a burst move, which is charged again on every `BURST_PERIOD`-th access after its first.

Charges that arrive while a stall is already running are queued. Each one lengthens the running stall by `STALL_LEN` clocks. The pending stall saturates at `MAX_CHARGES * STALL_LEN` clocks. The `stall` output is a plain level that the CPU holds its bus cycle on.

Top module: `bus_stall_gen`

## Requirements
- R1: During and straight after reset `stall` is low. After reset no instruction stamp is remembered, so the first valid access stalls even if its stamp is 0.
- R2: A valid access (`acc_strobe=1`, `acc_valid=1`) whose stamp differs from the stamp of the last valid access raises `stall` in the cycle after the sampling edge. When nothing else is pending, `stall` stays high for exactly `STALL_LEN` (4) cycles.
- R3: A valid access with the same stamp as the last valid access and `acc_burst=0` adds no stall.
- R4: For accesses with the same stamp and `acc_burst=1`, the block counts the accesses that follow the first one. It charges `STALL_LEN` cycles on every `BURST_PERIOD`-th (4th) of them, which is the 5th, 9th, ... access of the instruction.
- R5: The burst access count restarts from zero when a new stamp makes its first valid access.
- R6: An access with `acc_strobe=1` and `acc_valid=0` adds no stall. It also leaves the remembered stamp and the burst count unchanged.
- R7: A charge taken while `stall` is high lengthens the remaining stall. The remaining count is first reduced by one for the current cycle and then `STALL_LEN` is added to it, so two back-to-back charges give 7 stall cycles.
- R8: The pending stall never exceeds `MAX_CHARGES*STALL_LEN` (16) cycles. Any charge that would go beyond this limit is clipped to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_strobe | input | 1 | One peripheral access this cycle |
| acc_valid | input | 1 | Access passed the address-validity filter |
| acc_stamp | input | STAMP_W | Identifier of the instruction making the access |
| acc_burst | input | 1 | Access belongs to a multi-register burst move |
| stall | output | 1 | Hold the CPU bus cycle |

## Verification
The main function is driven with a single access under a fresh stamp, and with repeated accesses under one stamp both with and without the burst flag. These patterns separate the once-per-instruction charge from the every-fourth burst recharge. A burst run is then followed by a new stamp, which shows whether the access count restarts. Back-to-back charges, including a run of ten new stamps in a row, tell proper extension apart from restart, and proper saturation apart from wrap-around. Invalid accesses placed between valid ones show that the filtered access neither stalls nor disturbs the tracking state.

// File: rtl/bstall_pkg.sv
// Shared types for the peripheral access stall generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bstall_pkg;

    // Why an access is being charged a stall
    typedef enum logic [1:0] {
        CHG_NONE  = 2'd0,
        CHG_FIRST = 2'd1,
        CHG_BURST = 2'd2
    } charge_kind_t;

endpackage

// File: rtl/bstall_tracker.sv
// Instruction tracker: remembers the stamp of the last valid access and the
// burst access count, and decides whether the current access is charged.
// Assumes: at most one access per cycle; invalid accesses are fully ignored.
module bstall_tracker
    import bstall_pkg::*;
#(
    parameter int STAMP_W      = 16,
    parameter int BURST_PERIOD = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_strobe,
    input  logic               acc_valid,
    input  logic [STAMP_W-1:0] acc_stamp,
    input  logic               acc_burst,
    output charge_kind_t       kind
);

    localparam int CNT_W = (BURST_PERIOD > 1) ? $clog2(BURST_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURST_PERIOD - 1);

    logic [STAMP_W-1:0] stamp_q;
    logic               stamp_ok_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_next;
    logic               take;
    logic               is_new;
    logic               wrap;

    // Classify the current access and form the next burst count
    always_comb begin
        take     = acc_strobe && acc_valid;
        is_new   = !stamp_ok_q || (acc_stamp != stamp_q);
        wrap     = (cnt_q == CNT_LAST);
        cnt_next = wrap ? '0 : cnt_q + 1'b1;
        kind     = CHG_NONE;
        if (take) begin
            if (is_new)
                kind = CHG_FIRST;
            else if (acc_burst && wrap)
                kind = CHG_BURST;
        end
    end

    // Track the last valid stamp and the burst access count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q    <= '0;
            stamp_ok_q <= 1'b0;
            cnt_q      <= '0;
        end else if (take) begin
            if (is_new) begin
                stamp_q    <= acc_stamp;
                stamp_ok_q <= 1'b1;
                cnt_q      <= '0;
            end else if (acc_burst) begin
                cnt_q <= cnt_next;
            end
        end
    end

endmodule

// File: rtl/bstall_timer.sv
// Stall timer: holds the remaining stall length, counts it down, adds
// STALL_LEN per charge and clips at MAX_CHARGES*STALL_LEN.
// Assumes: at most one charge per cycle.
module bstall_timer #(
    parameter int STALL_LEN   = 4,
    parameter int MAX_CHARGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic charge,
    output logic stall
);

    localparam int REM_MAX = STALL_LEN * MAX_CHARGES;
    localparam int REM_W   = $clog2(REM_MAX + 1);
    localparam int SUM_W   = REM_W + 1;
    localparam logic [SUM_W-1:0] ADD_V = SUM_W'(STALL_LEN);
    localparam logic [SUM_W-1:0] CAP_V = SUM_W'(REM_MAX);

    logic [REM_W-1:0] rem_q;
    logic [SUM_W-1:0] dec;
    logic [SUM_W-1:0] sum;
    logic [REM_W-1:0] rem_d;

    // Count down one cycle, add a charge, clip at the cap
    always_comb begin
        dec = (rem_q != '0) ? {1'b0, rem_q} - 1'b1 : {1'b0, rem_q};
        sum = dec + ADD_V;
        if (!charge)
            rem_d = dec[REM_W-1:0];
        else if (sum > CAP_V)
            rem_d = CAP_V[REM_W-1:0];
        else
            rem_d = sum[REM_W-1:0];
    end

    // Remaining stall register
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= '0;
        else
            rem_q <= rem_d;
    end

    assign stall = (rem_q != '0);

endmodule

// File: rtl/bus_stall_gen.sv
// Top of the peripheral access stall generator: charges a stall on the first
// valid access of each instruction and on every BURST_PERIOD-th further access
// of a burst move; charges queue into one saturating stall counter.
// Assumes: acc_valid already reflects address filtering; one access per cycle.
module bus_stall_gen
    import bstall_pkg::*;
#(
    parameter int STAMP_W      = 16,
    parameter int STALL_LEN    = 4,
    parameter int BURST_PERIOD = 4,
    parameter int MAX_CHARGES  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_strobe,
    input  logic               acc_valid,
    input  logic [STAMP_W-1:0] acc_stamp,
    input  logic               acc_burst,
    output logic               stall
);

    charge_kind_t kind;
    logic         charge;

    bstall_tracker #(
        .STAMP_W     (STAMP_W),
        .BURST_PERIOD(BURST_PERIOD)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_strobe(acc_strobe),
        .acc_valid (acc_valid),
        .acc_stamp (acc_stamp),
        .acc_burst (acc_burst),
        .kind      (kind)
    );

    assign charge = (kind != CHG_NONE);

    bstall_timer #(
        .STALL_LEN  (STALL_LEN),
        .MAX_CHARGES(MAX_CHARGES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .charge(charge),
        .stall (stall)
    );

endmodule

// File: rtl/bus_stall_chk.sv
// Checker for bus_stall_gen, attached with bind. Keeps its own copy of the
// last valid stamp and a count of stall cycles since the last charge.
module bus_stall_chk #(
    parameter int STAMP_W     = 16,
    parameter int STALL_LEN   = 4,
    parameter int MAX_CHARGES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_strobe,
    input logic               acc_valid,
    input logic [STAMP_W-1:0] acc_stamp,
    input logic               acc_burst,
    input logic               charge,
    input logic               stall
);

    localparam int REM_MAX = STALL_LEN * MAX_CHARGES;

    logic [STAMP_W-1:0] last_q;
    logic               seen_q;
    int                 since_q;

    // Shadow of the last valid stamp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            seen_q <= 1'b0;
        end else if (acc_strobe && acc_valid) begin
            last_q <= acc_stamp;
            seen_q <= 1'b1;
        end
    end

    // Stall cycles since the most recent charge
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= 0;
        else if (charge)
            since_q <= 1;
        else if (stall)
            since_q <= since_q + 1;
        else
            since_q <= 0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !stall);

    // R2
    new_instr_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_strobe && acc_valid && (!seen_q || acc_stamp != last_q)) |=> stall);

    // R2
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(acc_strobe && acc_valid));

    // R3
    same_instr_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && acc_strobe && acc_valid && seen_q && acc_stamp == last_q && !acc_burst)
        |=> !stall);

    // R6
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && acc_strobe && !acc_valid) |=> !stall);

    // R7
    extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && charge) |=> stall);

    // R8
    cap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (since_q <= REM_MAX));

endmodule

bind bus_stall_gen bus_stall_chk #(
    .STAMP_W    (STAMP_W),
    .STALL_LEN  (STALL_LEN),
    .MAX_CHARGES(MAX_CHARGES)
) u_chk (.*);

// File: tb/bus_stall_gen_bench.sv
`timescale 1ns/1ps
module bus_stall_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_strobe = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_stamp = '0;
    logic        acc_burst = 1'b0;
    logic        stall;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_stall_gen u_bus_stall_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_strobe(acc_strobe),
        .acc_valid (acc_valid),
        .acc_stamp (acc_stamp),
        .acc_burst (acc_burst),
        .stall     (stall)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one access for one edge; returns at the negedge after it
    task automatic access(input logic v, input logic [15:0] s, input logic b);
        @(negedge clk);
        acc_strobe = 1'b1;
        acc_valid  = v;
        acc_stamp  = s;
        acc_burst  = b;
        @(negedge clk);
        acc_strobe = 1'b0;
        acc_valid  = 1'b0;
        acc_burst  = 1'b0;
    endtask

    // Count stall-high samples from now until it drops
    task automatic count_stall(output int n);
        n = 0;
        while (stall && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic access_len(input logic v, input logic [15:0] s, input logic b,
                              output int n);
        access(v, s, b);
        count_stall(n);
    endtask

    task automatic t_reset();
        int n;
        @(negedge clk);
        check("R1 stall in reset", int'(stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stall after reset", int'(stall), 0);
        access_len(1'b1, 16'd0, 1'b0, n);
        check("R1 first access stamp 0 stalls", n, 4);
    endtask

    task automatic t_single();
        int n;
        access_len(1'b1, 16'd7, 1'b0, n);
        check("R2 new stamp length", n, 4);
        access_len(1'b1, 16'd7, 1'b0, n);
        check("R3 same stamp non-burst", n, 0);
        access_len(1'b1, 16'd7, 1'b0, n);
        check("R3 same stamp non-burst again", n, 0);
    endtask

    task automatic t_burst();
        int n;
        access_len(1'b1, 16'd20, 1'b1, n);
        check("R4 burst first access", n, 4);
        for (int i = 2; i <= 9; i++) begin
            access_len(1'b1, 16'd20, 1'b1, n);
            check($sformatf("R4 burst access %0d", i), n, (i == 5 || i == 9) ? 4 : 0);
        end
    endtask

    task automatic t_restart();
        int n;
        access_len(1'b1, 16'd30, 1'b1, n);
        for (int i = 2; i <= 4; i++) access_len(1'b1, 16'd30, 1'b1, n);
        access_len(1'b1, 16'd31, 1'b1, n);
        check("R5 new burst instr first", n, 4);
        for (int i = 2; i <= 5; i++) begin
            access_len(1'b1, 16'd31, 1'b1, n);
            check($sformatf("R5 count restarted access %0d", i), n, (i == 5) ? 4 : 0);
        end
    endtask

    task automatic t_invalid();
        int n;
        access_len(1'b1, 16'd40, 1'b0, n);
        access_len(1'b0, 16'd41, 1'b0, n);
        check("R6 invalid new stamp no stall", n, 0);
        access_len(1'b1, 16'd40, 1'b0, n);
        check("R6 stamp kept after invalid", n, 0);
        access_len(1'b1, 16'd50, 1'b1, n);
        for (int i = 0; i < 4; i++) access_len(1'b0, 16'd50, 1'b1, n);
        check("R6 invalid burst no stall", n, 0);
        for (int i = 2; i <= 4; i++) access_len(1'b1, 16'd50, 1'b1, n);
        check("R6 count untouched by invalid", n, 0);
        access_len(1'b1, 16'd50, 1'b1, n);
        check("R6 fifth valid burst charges", n, 4);
    endtask

    task automatic t_extend();
        int n;
        @(negedge clk);
        acc_strobe = 1'b1; acc_valid = 1'b1; acc_burst = 1'b0; acc_stamp = 16'd60;
        @(negedge clk);
        acc_stamp = 16'd61;
        @(negedge clk);
        acc_strobe = 1'b0; acc_valid = 1'b0;
        count_stall(n);
        check("R7 two back-to-back charges", n, 7);
    endtask

    task automatic t_saturate();
        int n;
        @(negedge clk);
        acc_strobe = 1'b1; acc_valid = 1'b1; acc_burst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            acc_stamp = 16'(100 + i);
            @(negedge clk);
        end
        acc_strobe = 1'b0; acc_valid = 1'b0;
        count_stall(n);
        check("R8 saturated stall length", n, 16);
    endtask

    initial begin
        t_reset();
        t_single();
        t_burst();
        t_restart();
        t_invalid();
        t_extend();
        t_saturate();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule